// File: doc/BRIEF.md
# Atomic Word Operation Unit with Reservation Flag

This block carries out the word-sized atomic instructions of a 32-bit core. It handles load-reserved, store-conditional and nine read-modify-write operations. A request brings an operation code, a word address and a source operand (the rs2 value). The unit then drives a simple single-outstanding memory port. It finishes with a one-cycle `done` pulse that carries either a destination-register write or an exception cause.

The unit holds one reservation flag. A successful load-reserved sets it. A store-conditional succeeds only if the flag is set, and no address is compared. For a read-modify-write operation the unit reads the word, computes the new value, and writes it back. The old value goes to the destination register. The write is issued only after the read has returned without a fault. Faults in either phase of a read-modify-write operation are reported as store access faults.

Top module: `amo_unit`

## Requirements
- R1: After reset `done`, `busy` and `memReq` are low and the reservation flag is clear. A request is accepted only while `busy` is low, and every request ends with exactly one single-cycle `done` pulse.
- R2: A load-reserved (op 0) whose address has either of its two low bits set ends with `excValid` and cause 4. It issues no memory request and leaves the reservation flag unchanged.
- R3: A store-conditional (op 1) or read-modify-write operation (ops 2..10) with a misaligned address ends with cause 6. It issues no memory request and leaves the reservation flag unchanged.
- R4: A load-reserved whose read succeeds writes the read word to rd and sets the flag. If the read faults, it ends with cause 5, makes no rd write and does not set the flag.
- R5: A store-conditional that finds the flag set writes rs2 to the address and returns rd = 0. If that write faults, it ends with cause 7 and makes no rd write.
- R6: A store-conditional that finds the flag clear returns rd = 1 and issues no memory request.
- R7: Every aligned store-conditional clears the flag, whatever its outcome.
- R8: A read-modify-write operation issues exactly one read, then exactly one write to the same address. The write starts only after a read response without error. rd receives the old word.
- R9: If the read phase of a read-modify-write operation faults, it ends with cause 7, issues no write and makes no rd write.
- R10: If the write phase of a read-modify-write operation faults, it ends with cause 7 and makes no rd write.
- R11: The value written is as follows: swap (2) writes rs2, add (3) writes old+rs2 modulo 2^32, xor (4) writes old^rs2, and (5) writes old&rs2, or (6) writes old|rs2.
- R12: Minimum (7) and maximum (8) compare old and rs2 as signed two's-complement values. Unsigned minimum (9) and unsigned maximum (10) compare them as unsigned values. The selected value is the one written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while `busy` is low |
| reqOp | input | 4 | Operation code (0 LR, 1 SC, 2..10 read-modify-write) |
| reqAddr | input | ADDR_W | Word address of the access |
| reqData | input | DATA_W | Source operand (rs2) |
| busy | output | 1 | An operation is in progress |
| memReq | output | 1 | Memory access request, held until `memRsp` |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Write data |
| memRsp | input | 1 | Response for the current request |
| memErr | input | 1 | The response is an access fault |
| memRdata | input | DATA_W | Read data, valid with `memRsp` |
| done | output | 1 | One-cycle completion pulse |
| rdWe | output | 1 | Destination register write, valid with `done` |
| rdData | output | DATA_W | Destination register value |
| excValid | output | 1 | Exception raised, valid with `done` |
| excCause | output | 4 | Exception cause code (4, 5, 6 or 7) |

## Verification
The assertions assume that the memory side only raises `memRsp` while `memReq` is high, and gives exactly one response per phase. They also assume that requests arrive only while `busy` is low, with operation codes in the range 0..10. The bench keeps to these assumptions in two ways. Its memory model answers each request one cycle after seeing it, then drops the response. Each scenario task issues a single request and waits for `done` before the next task starts. Fault behaviour is reached through address bits in the memory model: bit 31 faults every access, and bit 30 faults writes only.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_XOR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_MINU = 4'd9,
    OP_MAXU = 4'd10
  } amoOp_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amoState_e;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_MEM  = 3'd1,
    RD_OLD  = 3'd2,
    RD_ZERO = 3'd3,
    RD_ONE  = 3'd4
  } rdSel_e;

  localparam logic [3:0] CAUSE_LD_MISALIGN = 4'd4;
  localparam logic [3:0] CAUSE_LD_FAULT    = 4'd5;
  localparam logic [3:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [3:0] CAUSE_ST_FAULT    = 4'd7;

  typedef struct packed {
    logic       latchReq;
    logic       captureOld;
    logic       setResult;
    rdSel_e     rdSel;
    logic       excSet;
    logic [3:0] excCause;
  } amoStrobe_t;

endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  amoOp_e     reqOp,
  input  logic       misaligned,
  input  logic       memRsp,
  input  logic       memErr,
  output amoOp_e     opQ,
  output amoStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       memWe,
  output logic       done
);

  amoState_e stateQ, stateD;
  logic      resvQ;
  logic      readOkQ;
  logic      reqIsLr, reqIsSc, acceptReq;

  assign reqIsLr   = (reqOp == OP_LR);
  assign reqIsSc   = (reqOp == OP_SC);
  assign acceptReq = (stateQ == ST_IDLE) && reqValid;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (misaligned) begin
            strobe.setResult = 1'b1;
            strobe.excSet    = 1'b1;
            strobe.excCause  = reqIsLr ? CAUSE_LD_MISALIGN : CAUSE_ST_MISALIGN;
            stateD           = ST_DONE;
          end else if (reqIsSc && !resvQ) begin
            strobe.setResult = 1'b1;
            strobe.rdSel     = RD_ONE;
            stateD           = ST_DONE;
          end else if (reqIsSc) begin
            stateD = ST_WRITE;
          end else begin
            stateD = ST_READ;
          end
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memRsp) begin
          if (memErr) begin
            strobe.setResult = 1'b1;
            strobe.excSet    = 1'b1;
            strobe.excCause  = (opQ == OP_LR) ? CAUSE_LD_FAULT : CAUSE_ST_FAULT;
            stateD           = ST_DONE;
          end else if (opQ == OP_LR) begin
            strobe.setResult = 1'b1;
            strobe.rdSel     = RD_MEM;
            stateD           = ST_DONE;
          end else begin
            strobe.captureOld = 1'b1;
            stateD            = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memRsp) begin
          strobe.setResult = 1'b1;
          if (memErr) begin
            strobe.excSet   = 1'b1;
            strobe.excCause = CAUSE_ST_FAULT;
          end else begin
            strobe.rdSel = (opQ == OP_SC) ? RD_ZERO : RD_OLD;
          end
          stateD = ST_DONE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      opQ     <= OP_LR;
      resvQ   <= 1'b0;
      readOkQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (acceptReq) begin
        opQ     <= reqOp;
        readOkQ <= 1'b0;
      end
      if (stateQ == ST_READ && memRsp && !memErr) readOkQ <= 1'b1;
      if (acceptReq && reqIsSc && !misaligned) resvQ <= 1'b0;
      else if (stateQ == ST_READ && memRsp && !memErr && opQ == OP_LR) resvQ <= 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_DONE);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WRITE && opQ != OP_SC) |-> readOkQ);

  a_r4_flag_set_by_lr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resvQ) |-> $past(opQ == OP_LR && memRsp && !memErr));

  a_r7_sc_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    (acceptReq && reqIsSc && !misaligned) |=> !resvQ);

  a_r3_misalign_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (acceptReq && misaligned) |=> (done && !memReq));

endmodule

// File: rtl/amo_dp.sv
module amo_dp
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  amoStrobe_t        strobe,
  input  amoOp_e            opQ,
  input  logic              done,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              misaligned,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdWe,
  output logic [DATA_W-1:0] rdData,
  output logic              excValid,
  output logic [3:0]        excCause
);

  localparam int ALIGN_W = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, oldQ, newVal, rdDataQ, rdPick;
  logic              rdWeQ, excValidQ;
  logic [3:0]        excCauseQ;
  logic              oldLtS, oldLtU;

  assign misaligned = |reqAddr[ALIGN_W-1:0];
  assign oldLtS     = $signed(oldQ) < $signed(dataQ);
  assign oldLtU     = oldQ < dataQ;

  always_comb begin
    unique case (opQ)
      OP_ADD:  newVal = oldQ + dataQ;
      OP_XOR:  newVal = oldQ ^ dataQ;
      OP_AND:  newVal = oldQ & dataQ;
      OP_OR:   newVal = oldQ | dataQ;
      OP_MIN:  newVal = oldLtS ? oldQ : dataQ;
      OP_MAX:  newVal = oldLtS ? dataQ : oldQ;
      OP_MINU: newVal = oldLtU ? oldQ : dataQ;
      OP_MAXU: newVal = oldLtU ? dataQ : oldQ;
      default: newVal = dataQ;
    endcase
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_MEM:  rdPick = memRdata;
      RD_OLD:  rdPick = oldQ;
      RD_ONE:  rdPick = DATA_W'(1);
      default: rdPick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      dataQ     <= '0;
      oldQ      <= '0;
      rdWeQ     <= 1'b0;
      rdDataQ   <= '0;
      excValidQ <= 1'b0;
      excCauseQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        addrQ     <= reqAddr;
        dataQ     <= reqData;
        rdWeQ     <= 1'b0;
        excValidQ <= 1'b0;
        excCauseQ <= '0;
      end
      if (strobe.captureOld) oldQ <= memRdata;
      if (strobe.setResult) begin
        rdWeQ     <= (strobe.rdSel != RD_NONE) && !strobe.excSet;
        rdDataQ   <= rdPick;
        excValidQ <= strobe.excSet;
        excCauseQ <= strobe.excCause;
      end
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = (opQ == OP_SC) ? dataQ : newVal;
  assign rdWe     = done && rdWeQ;
  assign rdData   = rdDataQ;
  assign excValid = done && excValidQ;
  assign excCause = excCauseQ;

  a_r10_exc_blocks_rd: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !rdWe);

  a_r5_sc_result_bit: assert property (@(posedge clk) disable iff (!rstN)
    (rdWe && opQ == OP_SC) |-> (rdData <= DATA_W'(1)));

  a_r9_cause_range: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCause >= 4'd4 && excCause <= 4'd7));

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRsp,
  input  logic              memErr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic              rdWe,
  output logic [DATA_W-1:0] rdData,
  output logic              excValid,
  output logic [3:0]        excCause
);

  amoStrobe_t strobe;
  amoOp_e     opQ;
  logic       misaligned;

  amo_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (amoOp_e'(reqOp)),
    .misaligned (misaligned),
    .memRsp     (memRsp),
    .memErr     (memErr),
    .opQ        (opQ),
    .strobe     (strobe),
    .busy       (busy),
    .memReq     (memReq),
    .memWe      (memWe),
    .done       (done)
  );

  amo_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opQ        (opQ),
    .done       (done),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .memRdata   (memRdata),
    .misaligned (misaligned),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .rdWe       (rdWe),
    .rdData     (rdData),
    .excValid   (excValid),
    .excCause   (excCause)
  );

endmodule

// File: tb/sim_amo_unit.sv
module sim_amo_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqOp = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        busy, memReq, memWe, done, rdWe, excValid;
  logic [31:0] memAddr, memWdata, rdData;
  logic [3:0]  excCause;
  logic        memRsp = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memRdata = '0;

  logic [31:0] memArr [16];
  int          rdCount = 0;
  int          wrCount = 0;
  int          nChecks = 0;
  int          nFail = 0;

  logic        resRdWe, resExc;
  logic [31:0] resRd;
  logic [3:0]  resCause;

  always #5 clk = ~clk;

  amo_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRsp(memRsp),
    .memErr(memErr), .memRdata(memRdata), .done(done), .rdWe(rdWe),
    .rdData(rdData), .excValid(excValid), .excCause(excCause)
  );

  // Memory model: bit 31 faults every access, bit 30 faults writes only.
  always @(negedge clk) begin
    if (!rstN) begin
      memRsp = 1'b0;
    end else if (memRsp) begin
      memRsp = 1'b0;
    end else if (memReq) begin
      memErr = memAddr[31] || (memWe && memAddr[30]);
      if (memWe) begin
        wrCount++;
        if (!memErr) memArr[memAddr[5:2]] = memWdata;
      end else begin
        rdCount++;
        memRdata = memErr ? 32'hDEAD_BEEF : memArr[memAddr[5:2]];
      end
      memRsp = 1'b1;
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finishRun();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] data);
    int guard = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk("R1 done pulse", 32'(done), 32'd1);
    resRdWe = rdWe; resRd = rdData; resExc = excValid; resCause = excCause;
    @(negedge clk);
    chk("R1 done single cycle", 32'(done), 32'd0);
  endtask

  function automatic logic [31:0] amoRef(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd2:  return b;
      4'd3:  return a + b;
      4'd4:  return a ^ b;
      4'd5:  return a & b;
      4'd6:  return a | b;
      4'd7:  return ($signed(a) < $signed(b)) ? a : b;
      4'd8:  return ($signed(a) > $signed(b)) ? a : b;
      4'd9:  return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  task automatic t_reset();
    int r0;
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 memReq after reset", 32'(memReq), 32'd0);
    r0 = rdCount + wrCount;
    runOp(4'd1, 32'h10, 32'h55);
    chk("R6 sc flag clear rd", resRd, 32'd1);
    chk("R6 sc flag clear rdWe", 32'(resRdWe), 32'd1);
    chk("R6 sc no mem access", 32'(rdCount + wrCount), 32'(r0));
  endtask

  task automatic t_lrSc();
    memArr[1] = 32'h1234_5678;
    runOp(4'd0, 32'h4, 32'h0);
    chk("R4 lr data", resRd, 32'h1234_5678);
    chk("R4 lr rdWe", 32'(resRdWe), 32'd1);
    runOp(4'd1, 32'h8, 32'h0000_CAFE);
    chk("R5 sc success rd", resRd, 32'd0);
    chk("R5 sc written", memArr[2], 32'h0000_CAFE);
    runOp(4'd1, 32'h8, 32'h1111_1111);
    chk("R7 flag cleared after sc", resRd, 32'd1);
    chk("R7 no second write", memArr[2], 32'h0000_CAFE);
  endtask

  task automatic t_lrFault();
    runOp(4'd0, 32'h8000_0004, 32'h0);
    chk("R4 lr fault exc", 32'(resExc), 32'd1);
    chk("R4 lr fault cause", 32'(resCause), 32'd5);
    chk("R4 lr fault no rd", 32'(resRdWe), 32'd0);
    runOp(4'd1, 32'hC, 32'h9);
    chk("R4 flag not set by faulted lr", resRd, 32'd1);
  endtask

  task automatic t_misalign();
    int r0;
    r0 = rdCount + wrCount;
    runOp(4'd0, 32'h2, 32'h0);
    chk("R2 lr misalign cause", 32'(resCause), 32'd4);
    chk("R2 lr misalign exc", 32'(resExc), 32'd1);
    runOp(4'd3, 32'h6, 32'h1);
    chk("R3 amo misalign cause", 32'(resCause), 32'd6);
    chk("R3 amo misalign no rd", 32'(resRdWe), 32'd0);
    runOp(4'd1, 32'h1, 32'h1);
    chk("R3 sc misalign cause", 32'(resCause), 32'd6);
    chk("R3 misalign no mem access", 32'(rdCount + wrCount), 32'(r0));
    memArr[3] = 32'hA5A5_0000;
    runOp(4'd0, 32'hC, 32'h0);
    runOp(4'd2, 32'hE, 32'h0);
    runOp(4'd1, 32'h3, 32'h0);
    runOp(4'd1, 32'hC, 32'h0BAD_F00D);
    chk("R3 flag kept across misaligned ops", resRd, 32'd0);
    chk("R5 sc write after kept flag", memArr[3], 32'h0BAD_F00D);
  endtask

  task automatic t_scFault();
    runOp(4'd0, 32'h4000_0010, 32'h0);
    chk("R4 lr in write-fault region", 32'(resRdWe), 32'd1);
    runOp(4'd1, 32'h4000_0010, 32'h77);
    chk("R5 sc write fault cause", 32'(resCause), 32'd7);
    chk("R5 sc write fault no rd", 32'(resRdWe), 32'd0);
    runOp(4'd1, 32'h10, 32'h77);
    chk("R7 flag cleared by faulted sc", resRd, 32'd1);
  endtask

  task automatic t_amoOps();
    logic [31:0] aVals [3];
    logic [31:0] bVals [3];
    int r0, w0;
    aVals[0] = 32'h8000_0001; bVals[0] = 32'h0000_0005;
    aVals[1] = 32'h7FFF_FFF0; bVals[1] = 32'hFFFF_FFF0;
    aVals[2] = 32'hFFFF_FFFF; bVals[2] = 32'h0000_0001;
    for (int p = 0; p < 3; p++) begin
      for (int op = 2; op <= 10; op++) begin
        memArr[5] = aVals[p];
        r0 = rdCount; w0 = wrCount;
        runOp(4'(op), 32'h14, bVals[p]);
        chk((op >= 7) ? "R12 old to rd" : "R8 old to rd", resRd, aVals[p]);
        chk((op >= 7) ? "R12 written value" : "R11 written value",
            memArr[5], amoRef(4'(op), aVals[p], bVals[p]));
        chk("R8 one read", 32'(rdCount - r0), 32'd1);
        chk("R8 one write", 32'(wrCount - w0), 32'd1);
      end
    end
  endtask

  task automatic t_amoFaults();
    int w0;
    w0 = wrCount;
    runOp(4'd3, 32'h8000_0018, 32'h5);
    chk("R9 read fault cause", 32'(resCause), 32'd7);
    chk("R9 read fault no rd", 32'(resRdWe), 32'd0);
    chk("R9 read fault no write", 32'(wrCount - w0), 32'd0);
    memArr[7] = 32'h0000_00AA;
    runOp(4'd2, 32'h4000_001C, 32'h5);
    chk("R10 write fault cause", 32'(resCause), 32'd7);
    chk("R10 write fault no rd", 32'(resRdWe), 32'd0);
    chk("R10 memory unchanged", memArr[7], 32'h0000_00AA);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) memArr[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lrSc();
    t_lrFault();
    t_misalign();
    t_scFault();
    t_amoOps();
    t_amoFaults();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule